// File: doc/BRIEF.md
# Dual-Mode Per-Processor Counter

This block is the counter that sits beside one processor in a multi-processor timer arrangement. A mode bit, held elsewhere in a shared system timer and delivered to this block as a level with a change strobe, selects one of two personalities. In counter mode the block is a periodic limit-compare timer. It counts in 500 ns ticks, wraps to zero when it reaches a programmable limit, latches a reached flag and raises an interrupt. In user mode the same storage becomes a 63-bit, software-loadable free-running counter. Software starts and stops it, reads and writes it as an upper and a lower 32-bit word, and it never interrupts.

Software reaches the block through a 32-bit register port indexed by word. The meaning of words 0 and 1 follows the current mode. The count steps in units of 0x200 per tick, so the nine least significant bits of every count and limit value are always zero.

Top module: `dual_mode_counter`

## Requirements
- R1: After reset the block is in counter mode with limit 0, count 0, reached flag clear, interrupt low, and word 3 reads 1 (running).
- R2: In counter mode with a nonzero limit of P units of 0x200, each tick adds 0x200 to the count. On the tick that would bring the count to the limit, the count returns to 0, the reached flag sets and irqOut goes high. A read of word 1 returns the reached flag in bit 31 and the count in bits 30..9.
- R3: In counter mode a read of word 0 returns the limit (bits 30..9, all other bits zero) and clears both the reached flag and the interrupt. A write to word 0 stores the written value ANDed with 0x7FFFFE00 as the limit, restarts the count at 0, and clears the reached flag and the interrupt.
- R4: A write to word 2 replaces the limit without touching the count. The new limit takes effect on the following ticks.
- R5: With limit 0 the counter runs free: the count keeps advancing, the reached flag stays clear and no interrupt is raised.
- R6: A mode strobe that selects user mode while in counter mode lowers the interrupt, stops the counter (word 3 reads 0), and clears the count and reached flag. A strobe that selects counter mode while in user mode clears the count and restarts it (word 3 reads 1) with the previous limit. A strobe requesting the mode already in effect changes nothing.
- R7: In user mode a read of word 0 returns the reached flag in bit 31 and count bits 62..32 in bits 30..0. A read of word 1 returns count bits 31..9 in bits 31..9, with bits 8..0 zero.
- R8: In user mode a write to word 0 loads count bits 62..32 from data bits 30..0, ignoring bit 31. A write to word 1 loads count bits 31..9 from data bits 31..9. Either write clears the reached flag and leaves the other half of the count unchanged.
- R9: In user mode, bit 0 of a write to word 3 starts (1) or stops (0) the counter. A write asking for the state already in effect does not restart or alter the count. In counter mode a write to word 3 has no effect.
- R10: In user mode the tick that would take the count to 0x7FFFFFFFFFFFFE00 returns it to 0 and sets the reached flag, and irqOut stays low throughout user mode.
- R11: A write to word 1 in counter mode and a write to word 4 are ignored. Reads of word 4 and of unmapped words return 0.
- R12: A register write that loads or clears the count takes precedence over a tick in the same cycle; that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (qualifies read side effects) |
| regAddr | input | 3 | Word index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the word at regAddr (combinational) |
| tick | input | 1 | One-cycle pulse every 500 ns |
| modeStrobe | input | 1 | Qualifies modeUser |
| modeUser | input | 1 | Requested mode: 1 user, 0 counter |
| irqOut | output | 1 | Interrupt, level |

## Verification
The bench goes after the wrap point in both modes. A comparator off by one unit would wrap a tick early or late and give a wrong period or count, and in user mode the ceiling is set up by loading a value one unit below it. It checks that mode transitions clear the interrupt and the running state. A design that kept counting, or left the interrupt pending, after the switch to user mode would show a moving count or a high irqOut. Redundant start writes, stray writes to words 1, 3 and 4 in the wrong mode, and a write colliding with a tick are all driven. A design that restarted, loaded or counted in those cases would return a count different from the one the bench computes.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef struct packed {
    logic clear;
    logic loadHi;
    logic loadLo;
    logic run;
  } dpcStrobe_t;
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 32,
  parameter int FRAC   = 9,
  localparam int LIM_W  = WORD_W - 1 - FRAC,
  localparam int LO_BITS = WORD_W - FRAC,
  localparam int CNT_W  = 2 * WORD_W - 1 - FRAC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              modeStrobe,
  input  logic              modeUser,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic              wrapEvt,
  output dpcStrobe_t        strb,
  output logic              userMode,
  output logic [LIM_W-1:0]  limitQ,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] W_HI    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] W_LO    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] W_NORST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] W_RUN   = ADDR_W'(3);

  logic running, reached, irqQ, modeChange;
  logic unusedCtrl;
  assign unusedCtrl = ^{regWrData[WORD_W-1], regWrData[FRAC-1:1]};

  assign modeChange = modeStrobe && (modeUser != userMode);
  assign irqOut = irqQ;

  always_comb begin
    strb.clear  = modeChange || (regWrEn && regAddr == W_HI && !userMode);
    strb.loadHi = !modeChange && regWrEn && regAddr == W_HI && userMode;
    strb.loadLo = !modeChange && regWrEn && regAddr == W_LO && userMode;
    strb.run    = running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      userMode <= 1'b0;
      running  <= 1'b1;
      limitQ   <= '0;
      reached  <= 1'b0;
      irqQ     <= 1'b0;
    end else if (modeChange) begin
      userMode <= modeUser;
      running  <= !modeUser;
      reached  <= 1'b0;
      irqQ     <= 1'b0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          W_HI: begin
            reached <= 1'b0;
            if (!userMode) begin
              limitQ <= regWrData[WORD_W-2:FRAC];
              irqQ   <= 1'b0;
            end
          end
          W_LO:    if (userMode) reached <= 1'b0;
          W_NORST: limitQ <= regWrData[WORD_W-2:FRAC];
          W_RUN:   if (userMode) running <= regWrData[0];
          default: ;
        endcase
      end
      if (regRdEn && regAddr == W_HI && !userMode) begin
        reached <= 1'b0;
        irqQ    <= 1'b0;
      end
      if (wrapEvt) begin
        if (userMode) reached <= 1'b1;
        else if (limitQ != '0) begin
          reached <= 1'b1;
          irqQ    <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      W_HI:  regRdData = userMode ? {reached, cntQ[CNT_W-1:LO_BITS]}
                                  : {1'b0, limitQ, {FRAC{1'b0}}};
      W_LO:  regRdData = userMode ? {cntQ[LO_BITS-1:0], {FRAC{1'b0}}}
                                  : {reached, cntQ[LIM_W-1:0], {FRAC{1'b0}}};
      W_RUN: regRdData = {{(WORD_W-1){1'b0}}, running};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FRAC   = 9,
  localparam int LIM_W   = WORD_W - 1 - FRAC,
  localparam int LO_BITS = WORD_W - FRAC,
  localparam int CNT_W   = 2 * WORD_W - 1 - FRAC,
  localparam int HI_BITS = CNT_W - LO_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  dpcStrobe_t        strb,
  input  logic              userMode,
  input  logic [LIM_W-1:0]  limitQ,
  input  logic [WORD_W-1:0] loadData,
  output logic [CNT_W-1:0]  cntQ,
  output logic              wrapEvt
);
  logic [CNT_W-1:0] ceilQ;
  logic [CNT_W:0]   nextQ;
  logic             advance, wrap;

  always_comb begin
    if (userMode)            ceilQ = '1;
    else if (limitQ == '0)   ceilQ = CNT_W'({LIM_W{1'b1}});
    else                     ceilQ = CNT_W'(limitQ);
  end

  assign nextQ   = {1'b0, cntQ} + 1'b1;
  assign wrap    = nextQ >= {1'b0, ceilQ};
  assign advance = tick && strb.run && !strb.clear && !strb.loadHi && !strb.loadLo;
  assign wrapEvt = advance && wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.clear) begin
      cntQ <= '0;
    end else if (strb.loadHi || strb.loadLo) begin
      if (strb.loadHi) cntQ[CNT_W-1:LO_BITS] <= loadData[HI_BITS-1:0];
      if (strb.loadLo) cntQ[LO_BITS-1:0]     <= loadData[WORD_W-1:FRAC];
    end else if (advance) begin
      cntQ <= wrap ? '0 : nextQ[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/dual_mode_counter.sv
module dual_mode_counter
  import dpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        tick,
  input  logic        modeStrobe,
  input  logic        modeUser,
  output logic        irqOut
);
  localparam int WORD_W = 32;
  localparam int FRAC   = 9;
  localparam int LIM_W  = WORD_W - 1 - FRAC;
  localparam int CNT_W  = 2 * WORD_W - 1 - FRAC;

  dpcStrobe_t       strb;
  logic             userMode, wrapEvt;
  logic [LIM_W-1:0] limitQ;
  logic [CNT_W-1:0] cntQ;

  dpc_ctrl #(.ADDR_W(3), .WORD_W(WORD_W), .FRAC(FRAC)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .modeStrobe(modeStrobe), .modeUser(modeUser), .cntQ(cntQ),
    .wrapEvt(wrapEvt), .strb(strb), .userMode(userMode),
    .limitQ(limitQ), .irqOut(irqOut)
  );

  dpc_datapath #(.WORD_W(WORD_W), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .userMode(userMode), .limitQ(limitQ), .loadData(regWrData),
    .cntQ(cntQ), .wrapEvt(wrapEvt)
  );
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker
  import dpc_pkg::*;
#(
  parameter int CNT_W = 54
) (
  input logic             clk,
  input logic             rstN,
  input logic             userMode,
  input logic             irqOut,
  input dpcStrobe_t       strb,
  input logic [CNT_W-1:0] cntQ,
  input logic             wrapEvt
);
  // R10: never an interrupt while in user mode
  p_no_irq_user_r10: assert property (@(posedge clk) disable iff (!rstN)
    userMode |-> !irqOut);

  // R6: entering user mode leaves the counter stopped
  p_enter_user_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userMode) |-> !strb.run);

  // R6: returning to counter mode leaves the counter running
  p_exit_user_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(userMode) |-> strb.run);

  // R9: a stopped counter with no load or clear keeps its value
  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clear && !strb.loadHi && !strb.loadLo) |=> $stable(cntQ));

  // R2: an interrupt only rises after a wrap
  p_irq_after_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(wrapEvt));

  // R2: a wrap leaves the count at zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrapEvt |=> (cntQ == '0));
endmodule

bind dual_mode_counter dpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .userMode(userMode), .irqOut(irqOut),
  .strb(strb), .cntQ(cntQ), .wrapEvt(wrapEvt)
);

// File: tb/sim_dual_mode_counter.sv
`timescale 1ns/1ps
module sim_dual_mode_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        tick = 1'b0, modeStrobe = 1'b0, modeUser = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_mode_counter u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tick(tick), .modeStrobe(modeStrobe), .modeUser(modeUser), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic wrTick(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; tick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic setMode(input logic u);
    @(negedge clk);
    modeStrobe = 1'b1; modeUser = u;
    @(negedge clk);
    modeStrobe = 1'b0;
  endtask

  function automatic logic [31:0] expLo(input int p, input int k);
    return {(k >= p) ? 1'b1 : 1'b0, 22'(k % p), 9'b0};
  endfunction

  function automatic logic [53:0] userVal(input logic [31:0] hi, input logic [31:0] lo, input int k);
    return {hi[30:0], lo[31:9]} + 54'(k);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d, hi, lo;
    logic [53:0] v;
    int p, k;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd1, d); chk("R1 count", d, 32'h0);
    rd(3'd3, d); chk("R1 running", d, 32'h1);
    rd(3'd0, d); chk("R1 limit", d, 32'h0);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);

    // R5 free run
    ticks(10);
    rd(3'd1, d); chk("R5 count", d, 32'(10 << 9));
    chk("R5 irq", {31'b0, irqOut}, 32'h0);

    // R2/R3 random limits
    for (int it = 0; it < 8; it++) begin
      p = 2 + int'($urandom % 20);
      k = int'($urandom % (3 * p));
      wr(3'd0, 32'(p << 9) | ($urandom & 32'h8000_01FF));
      ticks(k);
      rd(3'd1, d); chk("R2 count", d, expLo(p, k));
      chk("R2 irq", {31'b0, irqOut}, {31'b0, k >= p});
      rd(3'd0, d); chk("R3 limit read", d, 32'(p << 9));
      rd(3'd1, d); chk("R3 reached cleared", d[31], 1'b0);
      chk("R3 irq cleared", {31'b0, irqOut}, 32'h0);
    end

    // R4 limit change without reset
    wr(3'd0, 32'(20 << 9));
    ticks(5);
    wr(3'd2, 32'(10 << 9));
    rd(3'd1, d); chk("R4 count kept", d, 32'(5 << 9));
    ticks(5);
    rd(3'd1, d); chk("R4 wrap at new limit", d, 32'h8000_0000);
    chk("R4 irq", {31'b0, irqOut}, 32'h1);
    rd(3'd0, d);

    // R11 ignored writes
    wr(3'd0, 32'(100 << 9));
    ticks(3);
    wr(3'd1, 32'h1234_5600);
    rd(3'd1, d); chk("R11 word1 write ignored", d, 32'(3 << 9));
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R11 word4 reads zero", d, 32'h0);
    rd(3'd5, d); chk("R11 unmapped reads zero", d, 32'h0);
    wr(3'd3, 32'h0);
    rd(3'd3, d); chk("R9 counter-mode run write ignored", d, 32'h1);
    ticks(1);
    rd(3'd1, d); chk("R9 still counting", d, 32'(4 << 9));

    // R12 write beats tick
    wrTick(3'd0, 32'(50 << 9));
    rd(3'd1, d); chk("R12 load beats tick", d, 32'h0);

    // R6 redundant strobe keeps count
    ticks(2);
    setMode(1'b0);
    rd(3'd1, d); chk("R6 redundant strobe", d, 32'(2 << 9));

    // R6 enter user mode with irq pending
    wr(3'd0, 32'(2 << 9));
    ticks(2);
    chk("R6 irq before switch", {31'b0, irqOut}, 32'h1);
    setMode(1'b1);
    chk("R6 irq lowered", {31'b0, irqOut}, 32'h0);
    rd(3'd3, d); chk("R6 stopped", d, 32'h0);
    rd(3'd0, d); chk("R6 hi cleared", d, 32'h0);
    ticks(5);
    rd(3'd1, d); chk("R6 no count while stopped", d, 32'h0);

    // R9 start/stop
    wr(3'd3, 32'h1);
    ticks(4);
    rd(3'd1, d); chk("R9 started", d, 32'(4 << 9));
    wr(3'd3, 32'h1);
    ticks(1);
    rd(3'd1, d); chk("R9 redundant start", d, 32'(5 << 9));
    wr(3'd3, 32'h0);
    ticks(3);
    rd(3'd1, d); chk("R9 stopped count", d, 32'(5 << 9));
    rd(3'd3, d); chk("R9 run bit", d, 32'h0);

    // R8 masks
    wr(3'd0, 32'h8000_0005);
    rd(3'd0, d); chk("R8 hi mask", d, 32'h0000_0005);
    wr(3'd1, 32'hABCD_E1FF);
    rd(3'd1, d); chk("R8 lo load", d, 32'hABCD_E000);

    // R7/R8 random user loads
    for (int it = 0; it < 6; it++) begin
      hi = $urandom & 32'h3FFF_FFFF;
      lo = $urandom;
      k = int'($urandom % 40);
      wr(3'd0, hi);
      wr(3'd1, lo);
      wr(3'd3, 32'h1);
      ticks(k);
      wr(3'd3, 32'h0);
      v = userVal(hi, lo, k);
      rd(3'd0, d); chk("R7 hi word", d, {1'b0, v[53:23]});
      rd(3'd1, d); chk("R7 lo word", d, {v[22:0], 9'b0});
    end

    // R10 ceiling wrap in user mode
    wr(3'd0, 32'h7FFF_FFFF);
    wr(3'd1, 32'hFFFF_FC00);
    wr(3'd3, 32'h1);
    ticks(1);
    rd(3'd1, d); chk("R10 lo after wrap", d, 32'h0);
    rd(3'd0, d); chk("R10 reached set", d, 32'h8000_0000);
    chk("R10 no irq", {31'b0, irqOut}, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h0);
    rd(3'd0, d); chk("R8 load clears reached", d, 32'h0);

    // R6 back to counter mode, previous limit of 2 units
    ticks(2);
    setMode(1'b0);
    rd(3'd3, d); chk("R6 running again", d, 32'h1);
    rd(3'd1, d); chk("R6 count cleared", d, 32'h0);
    ticks(3);
    rd(3'd1, d); chk("R6 counter mode resumes", d, 32'h8000_0200);
    chk("R6 irq resumes", {31'b0, irqOut}, 32'h1);

    finishRun();
  end
endmodule